// File: doc/BRIEF.md
# Button Auto-Repeat Pulse Generator

This block watches one active-low push button and turns a held press into a train of single-tick press events. The button level is sampled only on cycles where a tick enable is high. Each low sample advances a hold counter by one, and each high sample clears it. The first low sample after a release produces one press event at once. While the button stays down the block adds repeat events, and these come faster at three hold-count thresholds. With the default thresholds the gap is eight ticks from count 32, four ticks from count 128 and two ticks from count 256.

A system with several buttons instantiates the block once per button and shares the tick enable between them. The event output comes from a register and changes only on a tick. Each event therefore lasts exactly one tick period, so a consumer that polls at the tick rate sees every event exactly once. All timing comes from the single hold counter. The counter saturates near its top value in a way that keeps the fastest repeat rate going for as long as the button is held.

Top module: `btn_autorepeat`

## Requirements
- R1: After reset `press_o` is 0 and the hold count is zero, so the first low sample after reset gives an immediate press event.
- R2: On cycles where `tick_i` is 0, `btn_n_i` is ignored: neither the hold count nor `press_o` changes, and a hold that continues across such cycles keeps counting from where it was.
- R3: A tick with `btn_n_i` = 1 (released) clears the hold count to zero and produces no event.
- R4: A tick that takes the hold count from 0 to 1 (the first low sample) sets `press_o` to 1.
- R5: For hold counts 2 to 31 no event is produced.
- R6: For hold counts 32 to 127 an event is produced exactly when the count is a multiple of 8.
- R7: For hold counts 128 to 255 an event is produced exactly when the count is a multiple of 4.
- R8: For hold counts of 256 and above an event is produced exactly when the count is even.
- R9: The hold counter never wraps back to zero while the button is held. Past its top value, events continue on every second tick without end, in the same phase as if the count had kept rising.
- R10: `press_o` is registered. It updates only on tick cycles and holds its value until the next tick, so each event is exactly one tick period long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Poll enable; the button is sampled on cycles where this is 1 |
| btn_n_i | input | 1 | Raw button level, 0 = pressed |
| press_o | output | 1 | Press event, 1 for one tick period per initial press or repeat |

## Verification
The bench builds the block with a 10-bit hold counter, so saturation at 1023 is reached after about a thousand held ticks. It can then follow the alternating count at the top for many more ticks and compare it with the plain even-count rule. Hold lengths that stop just before, at and just after each of the thresholds 32, 128 and 256 are swept. Some holds are polled every cycle and others with idle cycles in between, during which the button line is toggled.

// File: rtl/btnrep_pkg.sv
package btnrep_pkg;

   localparam int unsigned DEF_CNT_W      = 16;
   localparam int unsigned DEF_NUM_STAGES = 3;

   typedef enum logic [1:0] {
      HOLD_IDLE  = 2'd0,
      HOLD_COUNT = 2'd1,
      HOLD_SAT   = 2'd2
   } hold_phase_e;

endpackage

// File: rtl/btn_hold_counter.sv
module btn_hold_counter
   import btnrep_pkg::*;
#(
   parameter int unsigned CNT_W = DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             btn_n_i,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_d
);

   localparam logic [CNT_W-1:0] CNT_TOP  = '1;
   localparam logic [CNT_W-1:0] CNT_BACK = CNT_TOP - CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("btn_hold_counter: CNT_W must be at least 2");
   end

   hold_phase_e phase;

   always_comb begin
      if (btn_n_i)               phase = HOLD_IDLE;
      else if (cnt_q == CNT_TOP) phase = HOLD_SAT;
      else                       phase = HOLD_COUNT;
   end

   always_comb begin
      unique case (phase)
         HOLD_IDLE:  cnt_d = '0;
         HOLD_SAT:   cnt_d = CNT_BACK;
         HOLD_COUNT: cnt_d = cnt_q + CNT_W'(1);
         default:    cnt_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_d;
   end

   // R3: a released sample empties the counter
   p_cnt_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && btn_n_i) |=> (cnt_q == '0));

   // R9: a held button never lets the count fall back to zero
   p_cnt_nowrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !btn_n_i && cnt_q != '0) |=> (cnt_q != '0));

   // R2: without a tick the count is frozen
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/btn_repeat_decode.sv
module btn_repeat_decode
   import btnrep_pkg::*;
#(
   parameter int unsigned CNT_W      = DEF_CNT_W,
   parameter int unsigned NUM_STAGES = DEF_NUM_STAGES,
   parameter int unsigned STAGE_START [NUM_STAGES] = '{32, 128, 256},
   parameter int unsigned STAGE_LOG2  [NUM_STAGES] = '{3, 2, 1}
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic             fire_o
);

   logic [NUM_STAGES:0] hit;

   assign hit[0] = (cnt_i == CNT_W'(1));

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      localparam logic [CNT_W-1:0] TH = CNT_W'(STAGE_START[s]);
      localparam int unsigned      LG = STAGE_LOG2[s];

      if (LG < 1 || LG >= CNT_W) begin : g_bad_log
         $error("btn_repeat_decode: stage period exponent out of range");
      end
      if (STAGE_START[s] < 2) begin : g_bad_start
         $error("btn_repeat_decode: stage start must exceed the first-press count");
      end
      if (s > 0) begin : g_order
         if (STAGE_START[s] <= STAGE_START[s-1]) begin : g_bad_order
            $error("btn_repeat_decode: stage starts must ascend");
         end
         if (STAGE_LOG2[s] >= STAGE_LOG2[s-1]) begin : g_bad_rate
            $error("btn_repeat_decode: stage periods must shrink");
         end
      end

      assign hit[s+1] = (cnt_i >= TH) && (cnt_i[LG-1:0] == '0);
   end

   assign fire_o = |hit;

endmodule

// File: rtl/btn_autorepeat.sv
module btn_autorepeat
   import btnrep_pkg::*;
#(
   parameter int unsigned CNT_W      = DEF_CNT_W,
   parameter int unsigned NUM_STAGES = DEF_NUM_STAGES,
   parameter int unsigned STAGE_START [NUM_STAGES] = '{32, 128, 256},
   parameter int unsigned STAGE_LOG2  [NUM_STAGES] = '{3, 2, 1}
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic btn_n_i,
   output logic press_o
);

   localparam longint unsigned TOP_VAL   = (64'd1 << CNT_W) - 64'd1;
   localparam longint unsigned LAST_START = 64'(STAGE_START[NUM_STAGES-1]);
   localparam logic [CNT_W-1:0] FIRST_TH  = CNT_W'(STAGE_START[0]);
   localparam logic [CNT_W-1:0] SECOND_TH = (NUM_STAGES > 1) ? CNT_W'(STAGE_START[1]) : '1;
   localparam int unsigned      FIRST_LG  = STAGE_LOG2[0];

   if (NUM_STAGES < 1) begin : g_bad_stages
      $error("btn_autorepeat: at least one repeat stage is needed");
   end
   if (CNT_W >= 63) begin : g_bad_wide
      $error("btn_autorepeat: CNT_W too large");
   end
   if (TOP_VAL <= LAST_START + 64'd1) begin : g_bad_room
      $error("btn_autorepeat: counter too narrow for the last stage");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             fire;
   logic             press_q;

   btn_hold_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .btn_n_i (btn_n_i),
      .cnt_q   (cnt_q),
      .cnt_d   (cnt_d)
   );

   btn_repeat_decode #(
      .CNT_W       (CNT_W),
      .NUM_STAGES  (NUM_STAGES),
      .STAGE_START (STAGE_START),
      .STAGE_LOG2  (STAGE_LOG2)
   ) u_dec (
      .cnt_i  (cnt_d),
      .fire_o (fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      press_q <= 1'b0;
      else if (tick_i) press_q <= fire;
   end

   assign press_o = press_q;

   // R4: the first low sample gives an event right away
   p_first_press_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !btn_n_i && cnt_q == '0) |=> press_q);

   // R5: no event in the dead zone before the first repeat stage
   p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q > CNT_W'(1) && cnt_q < FIRST_TH) |-> !press_q);

   // R6: the slowest stage fires only on its period boundary
   p_slow_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (press_q && cnt_q > CNT_W'(1) && cnt_q < SECOND_TH) |-> (cnt_q[FIRST_LG-1:0] == '0));

   // R8: every repeat falls on an even count
   p_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (press_q && cnt_q > CNT_W'(1)) |-> !cnt_q[0]);

   // R3: a released count never carries an event
   p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> !press_q);

   // R10: the event only moves on a tick
   p_press_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i) |=> $stable(press_q));

endmodule

// File: tb/btn_autorepeat_bench.sv
`timescale 1ns/1ps
module btn_autorepeat_bench;

   localparam int unsigned CNT_W = 10;
   localparam int TOP = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_i = 1'b0;
   logic btn_n_i = 1'b1;
   logic press_o;

   int checks = 0;
   int fails = 0;
   int hold = 0;
   bit last_exp = 1'b0;

   always #4 clk = ~clk;

   btn_autorepeat #(
      .CNT_W (CNT_W)
   ) u_btn_autorepeat (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .btn_n_i (btn_n_i),
      .press_o (press_o)
   );

   function automatic bit expect_fire(int h);
      if (h == 1) return 1'b1;
      if (h >= 256 && h % 2 == 0) return 1'b1;
      if (h >= 128 && h % 4 == 0) return 1'b1;
      if (h >= 32 && h % 8 == 0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic string req_of(int h);
      if (h == 0) return "R3";
      if (h == 1) return "R4";
      if (h < 32) return "R5";
      if (h < 128) return "R6";
      if (h < 256) return "R7";
      if (h >= TOP) return "R9";
      return "R8";
   endfunction

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: press_o=%0b expected %0b (hold %0d)", req, act, exp, hold);
      end
   endtask

   // one poll, entered and left at a falling edge
   task automatic poll(bit pressed);
      btn_n_i = !pressed;
      tick_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick_i = 1'b0;
      hold = pressed ? hold + 1 : 0;
      last_exp = expect_fire(hold);
      chk(req_of(hold), press_o, last_exp);
   endtask

   // cycles without a tick while the button line is wiggled
   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         btn_n_i = ~btn_n_i;
         tick_i = 1'b0;
         @(posedge clk);
         @(negedge clk);
         chk("R2/R10", press_o, last_exp);
      end
   endtask

   task automatic hold_run(int len, int gap);
      for (int i = 0; i < len; i++) begin
         poll(1'b1);
         if (gap > 0) idle(gap);
      end
      poll(1'b0);
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", press_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", press_o, 1'b0);
      // R1: count starts at zero, so the first press fires
      poll(1'b1);
      poll(1'b0);
      // R3: released polls stay quiet
      for (int i = 0; i < 4; i++) poll(1'b0);
      // R9: long hold into saturation and beyond, polled every cycle
      hold_run(TOP + 90, 0);
      // threshold sweep around every stage boundary
      hold_run(1, 0);
      hold_run(2, 0);
      hold_run(31, 0);
      hold_run(32, 0);
      hold_run(33, 0);
      hold_run(127, 0);
      hold_run(128, 0);
      hold_run(129, 0);
      hold_run(255, 0);
      hold_run(256, 0);
      hold_run(257, 0);
      // R2: sparse polling with the line toggled between ticks
      hold_run(40, 2);
      hold_run(300, 1);
      hold_run(TOP + 6, 1);
      // R10: an event held through idle cycles, then dropped on next tick
      poll(1'b1);
      idle(3);
      poll(1'b1);
      poll(1'b0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule